// File: doc/BRIEF.md
# Path Parity and Remote Error Monitor

This block watches the byte stream of a received high-order path. It computes even bit-interleaved parity over every byte of each payload envelope and compares the result with the parity byte carried in the following frame. Mismatches are counted for performance monitoring. Each check also produces a remote error value that a transmit side can place in the return-direction status byte. The remote error values that the far end reports in its own status byte are counted as well.

Error accumulation and remote error reporting each have a separate mode input. Each mode selects either a bit basis or a block basis. All counters saturate. A latch strobe moves both counters into holding outputs and restarts them in the same cycle, so no event that arrives during the latch cycle is lost.

Top module: `path_parity_monitor`

## Requirements
- R1: After reset, both live counters, both holding outputs, `rei_out` and `bip_err` are zero.
- R2: The parity reference is the bitwise XOR of every byte accepted with `pay_valid` from one `frame_start` (included if `pay_valid` is high in that cycle) up to the next `frame_start`. On a `b3_strobe` cycle, `rx_byte` is compared with the reference of the most recently completed frame. `bip_err` is high for exactly the one cycle after the strobe when the two differ.
- R3: With `acc_block_mode` low, `bip_count` increases by the number of differing bit positions (0 to 8) on each check.
- R4: With `acc_block_mode` high, `bip_count` increases by one for each check that has any differing bit.
- R5: One cycle after a check, `rei_out` holds the number of differing bits when `rei_block_mode` is low. When `rei_block_mode` is high it holds 1 if any bit differs and 0 otherwise. `rei_out` never exceeds 8.
- R6: The accumulation mode and the reporting mode act independently. Either combination may be used at any time.
- R7: On a `g1_strobe` cycle, the remote error field in `rx_byte[7:4]` is added to `rei_count`. Field values 0 to 8 add their own value, and values 9 to 15 add zero. `rx_byte[3:0]` is ignored.
- R8: Both counters saturate at all ones (2^CNT_W - 1) and never wrap.
- R9: On `latch_stb`, each holding output takes the counter value from before that edge. Each counter restarts at the increment that arrives in that same cycle.
- R10: A `b3_strobe` that comes before any complete frame (fewer than two `frame_start` events seen) changes neither the counters, `bip_err` nor `rei_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received path byte |
| pay_valid | input | 1 | Byte belongs to the payload envelope (included in parity) |
| frame_start | input | 1 | First cycle of a new frame |
| b3_strobe | input | 1 | rx_byte carries the path parity byte |
| g1_strobe | input | 1 | rx_byte carries the path status byte |
| acc_block_mode | input | 1 | 1: count errored frames, 0: count errored bits |
| rei_block_mode | input | 1 | 1: report 0/1 per frame, 0: report errored bit count |
| latch_stb | input | 1 | Copy counters to holding outputs and restart them |
| bip_count | output | CNT_W | Live parity error counter |
| rei_count | output | CNT_W | Live received remote error counter |
| bip_hold | output | CNT_W | Parity error count captured at last latch |
| rei_hold | output | CNT_W | Remote error count captured at last latch |
| rei_out | output | 4 | Remote error value for the return direction |
| bip_err | output | 1 | One-cycle pulse on a parity mismatch |

## Verification
Random payload lengths and contents are sent with parity bytes that are either correct or flipped by a random mask. A zero mask shows that correct parity raises no error. Single-bit and all-bit masks separate bit counting from block counting. The two mode inputs are varied independently, so a swapped mode select shows up as a wrong `rei_out` or a wrong counter step. Status bytes carry random fields, including the 9 to 15 range, which separates clamping from plain addition. Directed cases cover a parity strobe before the first complete frame, a latch in the same cycle as an increment, and runs that drive both counters into saturation.

// File: rtl/path_parity_monitor.sv
module path_parity_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rx_byte,
  input  logic             pay_valid,
  input  logic             frame_start,
  input  logic             b3_strobe,
  input  logic             g1_strobe,
  input  logic             acc_block_mode,
  input  logic             rei_block_mode,
  input  logic             latch_stb,
  output logic [CNT_W-1:0] bip_count,
  output logic [CNT_W-1:0] rei_count,
  output logic [CNT_W-1:0] bip_hold,
  output logic [CNT_W-1:0] rei_hold,
  output logic [3:0]       rei_out,
  output logic             bip_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [3:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {{(CNT_W-3){1'b0}}, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  logic [7:0] acc_q, ref_q;
  logic       seen_q, ref_ok_q;

  wire [7:0] ref_now   = frame_start ? acc_q  : ref_q;
  wire       ref_valid = frame_start ? seen_q : ref_ok_q;
  wire       check     = b3_strobe && ref_valid;
  wire [7:0] diff      = rx_byte ^ ref_now;
  wire [3:0] bit_errs  = ones8(diff);
  wire       blk_err   = |diff;

  wire [3:0] bip_inc = !check ? 4'd0 : (acc_block_mode ? {3'b000, blk_err} : bit_errs);
  wire [3:0] g1_fld  = rx_byte[7:4];
  wire [3:0] rei_inc = (g1_strobe && g1_fld <= 4'd8) ? g1_fld : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      ref_q    <= '0;
      seen_q   <= 1'b0;
      ref_ok_q <= 1'b0;
    end else if (frame_start) begin
      acc_q    <= pay_valid ? rx_byte : 8'h00;
      ref_q    <= acc_q;
      ref_ok_q <= seen_q;
      seen_q   <= 1'b1;
    end else if (pay_valid) begin
      acc_q    <= acc_q ^ rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bip_count <= '0;
      rei_count <= '0;
      bip_hold  <= '0;
      rei_hold  <= '0;
    end else if (latch_stb) begin
      bip_hold  <= bip_count;
      rei_hold  <= rei_count;
      bip_count <= {{(CNT_W-4){1'b0}}, bip_inc};
      rei_count <= {{(CNT_W-4){1'b0}}, rei_inc};
    end else begin
      bip_count <= sat_add(bip_count, bip_inc);
      rei_count <= sat_add(rei_count, rei_inc);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bip_err <= 1'b0;
      rei_out <= '0;
    end else begin
      bip_err <= check && blk_err;
      if (check) rei_out <= rei_block_mode ? {3'b000, blk_err} : bit_errs;
    end
  end

endmodule

// File: rtl/path_parity_monitor_chk.sv
module path_parity_monitor_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             b3_strobe,
  input logic             g1_strobe,
  input logic             latch_stb,
  input logic [CNT_W-1:0] bip_count,
  input logic [CNT_W-1:0] rei_count,
  input logic [CNT_W-1:0] bip_hold,
  input logic [CNT_W-1:0] rei_hold,
  input logic [3:0]       rei_out,
  input logic             bip_err
);

  assert_err_after_b3_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bip_err |-> $past(b3_strobe));

  assert_rei_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rei_out <= 4'd8);

  assert_err_has_rei_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bip_err |-> rei_out != 4'd0);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> bip_count >= $past(bip_count));

  assert_rei_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_stb |=> rei_count >= $past(rei_count));

  assert_latch_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    latch_stb |=> (bip_hold == $past(bip_count)) && (rei_hold == $past(rei_count)));

  assert_bip_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!b3_strobe && !latch_stb) |=> $stable(bip_count));

  assert_rei_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!g1_strobe && !latch_stb) |=> $stable(rei_count));

endmodule

bind path_parity_monitor path_parity_monitor_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .b3_strobe(b3_strobe), .g1_strobe(g1_strobe),
  .latch_stb(latch_stb), .bip_count(bip_count), .rei_count(rei_count),
  .bip_hold(bip_hold), .rei_hold(rei_hold), .rei_out(rei_out), .bip_err(bip_err)
);

// File: tb/path_parity_monitor_tb_top.sv
module path_parity_monitor_tb_top;
  localparam int CW = 6;
  localparam int MAXV = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] rx_byte = '0;
  logic pay_valid = 0, frame_start = 0, b3_strobe = 0, g1_strobe = 0;
  logic acc_block_mode = 0, rei_block_mode = 0, latch_stb = 0;
  logic [CW-1:0] bip_count, rei_count, bip_hold, rei_hold;
  logic [3:0] rei_out;
  logic bip_err;

  always #4 clk = ~clk;

  path_parity_monitor #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .pay_valid(pay_valid),
    .frame_start(frame_start), .b3_strobe(b3_strobe), .g1_strobe(g1_strobe),
    .acc_block_mode(acc_block_mode), .rei_block_mode(rei_block_mode),
    .latch_stb(latch_stb), .bip_count(bip_count), .rei_count(rei_count),
    .bip_hold(bip_hold), .rei_hold(rei_hold), .rei_out(rei_out), .bip_err(bip_err)
  );

  int checks = 0, failures = 0;
  logic [7:0] cur_par = '0, prev_par = '0;
  bit have_cur = 0, have_prev = 0;
  int m_bip = 0, m_rei = 0, m_rei_out = 0;

  function automatic int popc(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  function automatic int fld_val(input logic [3:0] f);
    return (f > 4'd8) ? 0 : int'(f);
  endfunction

  function automatic int sat(input int a, input int b);
    return (a + b > MAXV) ? MAXV : a + b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input bit v, input logic [7:0] b, input bit fs, input bit b3, input bit g1, input bit lt);
    pay_valid = v; rx_byte = b; frame_start = fs; b3_strobe = b3; g1_strobe = g1; latch_stb = lt;
    @(negedge clk);
    pay_valid = 0; rx_byte = '0; frame_start = 0; b3_strobe = 0; g1_strobe = 0; latch_stb = 0;
  endtask

  task automatic start_frame();
    tick(0, 8'h00, 1, 0, 0, 0);
    prev_par = cur_par; have_prev = have_cur; have_cur = 1; cur_par = '0;
  endtask

  task automatic payload(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      tick(1, b, 0, 0, 0, 0);
      cur_par ^= b;
    end
  endtask

  task automatic send_b3(input logic [7:0] mask, input string req);
    logic [7:0] b = prev_par ^ mask;
    int e_err = 0;
    if (have_prev) begin
      e_err = (mask != 0);
      m_bip = sat(m_bip, acc_block_mode ? e_err : popc(mask));
      m_rei_out = rei_block_mode ? e_err : popc(mask);
    end
    tick(1, b, 0, 1, 0, 0);
    cur_par ^= b;
    check({req, " bip_err"}, int'(bip_err), e_err);
    check({req, " rei_out"}, int'(rei_out), m_rei_out);
    check({req, " bip_count"}, int'(bip_count), m_bip);
    tick(0, 8'h00, 0, 0, 0, 0);
    check("R2 pulse width", int'(bip_err), 0);
  endtask

  task automatic send_g1(input logic [3:0] f);
    logic [7:0] b = {f, 4'($urandom)};
    m_rei = sat(m_rei, fld_val(f));
    tick(1, b, 0, 0, 1, 0);
    cur_par ^= b;
    check("R7 rei_count", int'(rei_count), m_rei);
  endtask

  task automatic do_latch(input string req);
    tick(0, 8'h00, 0, 0, 0, 1);
    check({req, " bip_hold"}, int'(bip_hold), m_bip);
    check({req, " rei_hold"}, int'(rei_hold), m_rei);
    m_bip = 0; m_rei = 0;
    check({req, " bip_count restart"}, int'(bip_count), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 bip_count", int'(bip_count), 0);
    check("R1 rei_count", int'(rei_count), 0);
    check("R1 bip_hold", int'(bip_hold), 0);
    check("R1 rei_hold", int'(rei_hold), 0);
    check("R1 rei_out", int'(rei_out), 0);
    check("R1 bip_err", int'(bip_err), 0);

    // R10: parity strobe before any complete frame
    start_frame();
    payload(5);
    send_b3(8'hA5, "R10");

    start_frame();
    payload(7);
    send_b3(8'h00, "R2 clean");
    start_frame();
    payload(4);
    send_b3(8'h01, "R3 one bit");
    start_frame();
    payload(6);
    send_b3(8'hFF, "R3 all bits");
    acc_block_mode = 1;
    start_frame();
    payload(3);
    send_b3(8'h0E, "R4 block acc, R6 bit rei");
    rei_block_mode = 1; acc_block_mode = 0;
    start_frame();
    payload(5);
    send_b3(8'h70, "R6 bit acc, R5 block rei");
    send_g1(4'd8);
    send_g1(4'd9);
    send_g1(4'd15);
    do_latch("R9 latch");

    // R9: latch in the same cycle as a status byte
    send_g1(4'd3);
    begin
      logic [7:0] b = {4'd5, 4'hC};
      tick(1, b, 0, 0, 1, 1);
      cur_par ^= b;
      check("R9 same-cycle hold", int'(rei_hold), m_rei);
      m_rei = 5; m_bip = 0;
      check("R9 same-cycle restart", int'(rei_count), 5);
    end

    // random mix
    for (int it = 0; it < 60; it++) begin
      acc_block_mode = $urandom % 2;
      rei_block_mode = $urandom % 2;
      start_frame();
      payload(1 + $urandom % 9);
      send_b3(($urandom % 2) ? 8'($urandom) : 8'h00, "R2 random");
      send_g1(4'($urandom));
      payload($urandom % 3);
      if ($urandom % 5 == 0) do_latch("R9 random");
    end

    // R8: saturation
    do_latch("R8 pre");
    acc_block_mode = 0;
    for (int k = 0; k < 12; k++) begin
      start_frame();
      payload(2);
      send_b3(8'hFF, "R8 bip");
      send_g1(4'd8);
    end
    check("R8 bip saturated", int'(bip_count), MAXV);
    check("R8 rei saturated", int'(rei_count), MAXV);
    do_latch("R8 hold");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule